// File: doc/BRIEF.md
# Exception Entry Control Unit

This unit turns one pending trap into the full set of values the processor core needs to enter an exception handler. In the cycle after a trap request, it provides the target processor mode, the updated status word, the handler address and the return address for the target mode's link register. It also provides a strobe that saves the current status into the target mode's saved-status register, plus a PC-load strobe and a pipeline-flush strobe.

Each trap kind carries its own mode number, vector offset, return-address rule and interrupt-mask rule. A configuration input moves the whole vector table from address zero to a high base. Banked register storage and the choice between competing interrupts are left to neighbouring blocks. The unit only encodes the entry rules for the trap it is given.

All outputs are registered. A trap presented in cycle N shows on the outputs in cycle N+1. When no trap is taken, the status output follows the current status with the same one-cycle delay.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, every strobe is low and every data output is zero.
- R2: Trap kind codes are 0 reset, 1 undefined, 2 software interrupt, 3 prefetch abort, 4 data abort, 5 IRQ, 6 FIQ. The target mode is 5'b10011 for kinds 0 and 2, 5'b11011 for kind 1, 5'b10111 for kinds 3 and 4, 5'b10010 for kind 5 and 5'b10001 for kind 6.
- R3: `pc_target` is the base plus the kind's offset. The offsets are 0x00, 0x04, 0x08, 0x0C, 0x10, 0x18 and 0x1C for kinds 0 to 6. The base is 0xFFFF0000 when `hivec_en` is high and zero otherwise.
- R4: On entry, `new_status` has bits [4:0] equal to the target mode, bit 5 (T) cleared and bit 7 (I) set. Bits [31:8] are copied from `cur_status`.
- R5: Bit 6 (F) of `new_status` is set for kinds 0 and 6. For all other kinds it equals bit 6 of `cur_status`.
- R6: `link_val` is `next_addr` for kinds 1 and 2 and `next_addr`+4 for kinds 5 and 6. It is `fault_addr`+4 for kind 3 and `fault_addr`+8 for kind 4. For all of these kinds `link_we` is high. For kind 0, `link_we` is low and `link_val` is zero.
- R7: For every kind except 0, `save_we` is high and `save_val` equals the `cur_status` presented with the trap. For kind 0, `save_we` is low and `save_val` is zero.
- R8: A trap with `trap_vld` high and a kind code from 0 to 6 raises `pc_load` and `flush` together in the next cycle, for exactly one cycle per trap.
- R9: When no trap is taken, all strobes are low in the next cycle. `new_status` equals the previous cycle's `cur_status`, `tgt_mode` equals its bits [4:0], and `pc_target`, `link_val` and `save_val` are zero.
- R10: Kind code 7 is reserved. With `trap_vld` high it has the same effect as no trap (R9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_vld | input | 1 | A trap is pending this cycle |
| trap_kind | input | 3 | Trap kind code |
| cur_status | input | 32 | Current status word |
| hivec_en | input | 1 | Select the high vector base |
| fault_addr | input | 32 | Address of the faulting instruction |
| next_addr | input | 32 | Address of the next instruction |
| pc_load | output | 1 | Load `pc_target` into the program counter |
| pc_target | output | 32 | Handler address |
| flush | output | 1 | Flush the pipeline |
| tgt_mode | output | 5 | Mode being entered (current mode when idle) |
| new_status | output | 32 | Status word to install |
| link_we | output | 1 | Write `link_val` into the target mode's link register |
| link_val | output | 32 | Return address |
| save_we | output | 1 | Write `save_val` into the target mode's saved status |
| save_val | output | 32 | Status word to save |

## Verification
Because all outputs come from one register stage, a wrong decode or a wrong stored value shows up on the very next cycle. It appears as a bad mode, offset, mask bit or return address on the pins, with no delay that could hide it. A strobe stuck high would show as a second `pc_load` on an idle cycle. A stale register would show as `new_status` lagging `cur_status` by more than one cycle. Random trap streams sent back to back catch state that leaks from one trap into the next. Directed passes cover every kind under both vector bases.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    typedef enum logic [2:0] {
        TRAP_RESET = 3'd0,
        TRAP_UNDEF = 3'd1,
        TRAP_SWI   = 3'd2,
        TRAP_PABT  = 3'd3,
        TRAP_DABT  = 3'd4,
        TRAP_IRQ   = 3'd5,
        TRAP_FIQ   = 3'd6,
        TRAP_RSVD  = 3'd7
    } trap_kind_e;

    typedef enum logic [2:0] {
        LNK_NONE   = 3'd0,
        LNK_NEXT   = 3'd1,
        LNK_NEXT4  = 3'd2,
        LNK_FAULT4 = 3'd3,
        LNK_FAULT8 = 3'd4
    } link_sel_e;

    localparam logic [4:0] MODE_SUPV = 5'b10011;
    localparam logic [4:0] MODE_UNDF = 5'b11011;
    localparam logic [4:0] MODE_ABRT = 5'b10111;
    localparam logic [4:0] MODE_IREQ = 5'b10010;
    localparam logic [4:0] MODE_FREQ = 5'b10001;

    localparam int MODE_W = 5;
    localparam int BIT_T  = 5;
    localparam int BIT_F  = 6;
    localparam int BIT_I  = 7;

    typedef struct packed {
        logic            taken;
        logic [4:0]      mode;
        logic [7:0]      offset;
        logic            set_f;
        logic            save;
        link_sel_e       lsel;
    } trap_attr_t;

endpackage

// File: rtl/exc_decode.sv
module exc_decode
    import exc_entry_pkg::*;
(
    input  logic       vld,
    input  logic [2:0] kind,
    output trap_attr_t attr
);
    always_comb begin
        attr = '{taken: 1'b0, mode: 5'd0, offset: 8'd0, set_f: 1'b0,
                 save: 1'b0, lsel: LNK_NONE};
        if (vld) begin
            attr.taken = 1'b1;
            attr.save  = 1'b1;
            unique case (trap_kind_e'(kind))
                TRAP_RESET: begin
                    attr.mode = MODE_SUPV; attr.offset = 8'h00;
                    attr.set_f = 1'b1; attr.save = 1'b0; attr.lsel = LNK_NONE;
                end
                TRAP_UNDEF: begin
                    attr.mode = MODE_UNDF; attr.offset = 8'h04; attr.lsel = LNK_NEXT;
                end
                TRAP_SWI: begin
                    attr.mode = MODE_SUPV; attr.offset = 8'h08; attr.lsel = LNK_NEXT;
                end
                TRAP_PABT: begin
                    attr.mode = MODE_ABRT; attr.offset = 8'h0C; attr.lsel = LNK_FAULT4;
                end
                TRAP_DABT: begin
                    attr.mode = MODE_ABRT; attr.offset = 8'h10; attr.lsel = LNK_FAULT8;
                end
                TRAP_IRQ: begin
                    attr.mode = MODE_IREQ; attr.offset = 8'h18; attr.lsel = LNK_NEXT4;
                end
                TRAP_FIQ: begin
                    attr.mode = MODE_FREQ; attr.offset = 8'h1C;
                    attr.set_f = 1'b1; attr.lsel = LNK_NEXT4;
                end
                default: begin
                    attr.taken = 1'b0; attr.save = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/exc_vector.sv
module exc_vector #(
    parameter int          AW      = 32,
    parameter logic [31:0] HI_BASE = 32'hFFFF_0000
) (
    input  logic          hivec,
    input  logic [7:0]    offset,
    output logic [AW-1:0] target
);
    localparam logic [AW-1:0] HIB = AW'(HI_BASE);
    localparam bit LOW_CLEAR = (HIB[7:0] == 8'd0);

    logic [AW-1:0] base;
    assign base = hivec ? HIB : '0;

    generate
        if (LOW_CLEAR) begin : g_or
            assign target = base | AW'(offset);
        end else begin : g_add
            assign target = base + AW'(offset);
        end
    endgenerate
endmodule

// File: rtl/exc_link.sv
module exc_link
    import exc_entry_pkg::*;
#(
    parameter int AW = 32
) (
    input  link_sel_e     lsel,
    input  logic [AW-1:0] fault_addr,
    input  logic [AW-1:0] next_addr,
    output logic [AW-1:0] link
);
    localparam logic [AW-1:0] FOUR  = AW'(4);
    localparam logic [AW-1:0] EIGHT = AW'(8);

    always_comb begin
        unique case (lsel)
            LNK_NEXT:   link = next_addr;
            LNK_NEXT4:  link = next_addr + FOUR;
            LNK_FAULT4: link = fault_addr + FOUR;
            LNK_FAULT8: link = fault_addr + EIGHT;
            default:    link = '0;
        endcase
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int          AW      = 32,
    parameter int          SW      = 32,
    parameter logic [31:0] HI_BASE = 32'hFFFF_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trap_vld,
    input  logic [2:0]    trap_kind,
    input  logic [SW-1:0] cur_status,
    input  logic          hivec_en,
    input  logic [AW-1:0] fault_addr,
    input  logic [AW-1:0] next_addr,
    output logic          pc_load,
    output logic [AW-1:0] pc_target,
    output logic          flush,
    output logic [4:0]    tgt_mode,
    output logic [SW-1:0] new_status,
    output logic          link_we,
    output logic [AW-1:0] link_val,
    output logic          save_we,
    output logic [SW-1:0] save_val
);
    typedef struct packed {
        logic          load;
        logic [AW-1:0] target;
        logic [4:0]    mode;
        logic [SW-1:0] status;
        logic          lwe;
        logic [AW-1:0] link;
        logic          swe;
        logic [SW-1:0] saved;
    } out_t;

    trap_attr_t    attr;
    logic [AW-1:0] vec_addr;
    logic [AW-1:0] ret_addr;
    out_t          st_d, st_q;

    exc_decode u_dec (
        .vld  (trap_vld),
        .kind (trap_kind),
        .attr (attr)
    );

    exc_vector #(.AW(AW), .HI_BASE(HI_BASE)) u_vec (
        .hivec  (hivec_en),
        .offset (attr.offset),
        .target (vec_addr)
    );

    exc_link #(.AW(AW)) u_lnk (
        .lsel       (attr.lsel),
        .fault_addr (fault_addr),
        .next_addr  (next_addr),
        .link       (ret_addr)
    );

    always_comb begin
        st_d        = '0;
        st_d.status = cur_status;
        st_d.mode   = cur_status[MODE_W-1:0];
        if (attr.taken) begin
            st_d.load                  = 1'b1;
            st_d.target                = vec_addr;
            st_d.mode                  = attr.mode;
            st_d.status[MODE_W-1:0]    = attr.mode;
            st_d.status[BIT_T]         = 1'b0;
            st_d.status[BIT_I]         = 1'b1;
            st_d.status[BIT_F]         = attr.set_f | cur_status[BIT_F];
            st_d.lwe                   = (attr.lsel != LNK_NONE);
            st_d.link                  = ret_addr;
            st_d.swe                   = attr.save;
            st_d.saved                 = attr.save ? cur_status : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc_load    = st_q.load;
    assign flush      = st_q.load;
    assign pc_target  = st_q.target;
    assign tgt_mode   = st_q.mode;
    assign new_status = st_q.status;
    assign link_we    = st_q.lwe;
    assign link_val   = st_q.link;
    assign save_we    = st_q.swe;
    assign save_val   = st_q.saved;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int AW = 32,
    parameter int SW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          trap_vld,
    input logic [2:0]    trap_kind,
    input logic [SW-1:0] cur_status,
    input logic          hivec_en,
    input logic [AW-1:0] fault_addr,
    input logic [AW-1:0] next_addr,
    input logic          pc_load,
    input logic [AW-1:0] pc_target,
    input logic          flush,
    input logic [4:0]    tgt_mode,
    input logic [SW-1:0] new_status,
    input logic          link_we,
    input logic [AW-1:0] link_val,
    input logic          save_we,
    input logic [SW-1:0] save_val
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_LOAD_FOLLOWS_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (pc_load == ($past(trap_vld) && $past(trap_kind) != 3'd7))); // R8
    AST_FLUSH_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        flush == pc_load); // R8
    AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> (!new_status[5] && new_status[7] && new_status[4:0] == tgt_mode)); // R4
    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && pc_load) |-> new_status[SW-1:8] == $past(cur_status[SW-1:8])); // R4
    AST_SAVE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && save_we) |-> (pc_load && save_val == $past(cur_status))); // R7
    AST_LINK_ONLY_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> pc_load); // R6
    AST_VECTOR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> pc_target[1:0] == 2'b00); // R3
    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !pc_load) |-> (new_status == $past(cur_status) && !save_we && !link_we)); // R9
endmodule

bind exc_entry_ctrl exc_entry_chk #(.AW(AW), .SW(SW)) u_chk (.*);

// File: tb/exc_entry_ctrl_bench.sv
`timescale 1ns/1ps
module exc_entry_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        trap_vld;
    logic [2:0]  trap_kind;
    logic [31:0] cur_status;
    logic        hivec_en;
    logic [31:0] fault_addr;
    logic [31:0] next_addr;
    logic        pc_load, flush, link_we, save_we;
    logic [31:0] pc_target, new_status, link_val, save_val;
    logic [4:0]  tgt_mode;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    exc_entry_ctrl u_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .trap_vld(trap_vld), .trap_kind(trap_kind),
        .cur_status(cur_status), .hivec_en(hivec_en), .fault_addr(fault_addr),
        .next_addr(next_addr), .pc_load(pc_load), .pc_target(pc_target),
        .flush(flush), .tgt_mode(tgt_mode), .new_status(new_status),
        .link_we(link_we), .link_val(link_val), .save_we(save_we),
        .save_val(save_val)
    );

    typedef struct packed {
        logic        ld;
        logic [31:0] tgt;
        logic [4:0]  md;
        logic [31:0] st;
        logic        lwe;
        logic [31:0] lnk;
        logic        swe;
        logic [31:0] sv;
    } exp_t;

    function automatic exp_t model(input logic v, input logic [2:0] k,
                                   input logic [31:0] cs, input logic hv,
                                   input logic [31:0] fa, input logic [31:0] na);
        exp_t e;
        logic [4:0] m;
        logic [31:0] off;
        e = '0;
        e.st = cs;
        e.md = cs[4:0];
        if (!v || k == 3'd7) return e;
        case (k)
            3'd0: begin m = 5'b10011; off = 32'h00; end
            3'd1: begin m = 5'b11011; off = 32'h04; e.lnk = na; end
            3'd2: begin m = 5'b10011; off = 32'h08; e.lnk = na; end
            3'd3: begin m = 5'b10111; off = 32'h0C; e.lnk = fa + 32'd4; end
            3'd4: begin m = 5'b10111; off = 32'h10; e.lnk = fa + 32'd8; end
            3'd5: begin m = 5'b10010; off = 32'h18; e.lnk = na + 32'd4; end
            default: begin m = 5'b10001; off = 32'h1C; e.lnk = na + 32'd4; end
        endcase
        e.ld  = 1'b1;
        e.md  = m;
        e.tgt = (hv ? 32'hFFFF_0000 : 32'h0) + off;
        e.st  = {cs[31:8], 1'b1, (k == 3'd0 || k == 3'd6) ? 1'b1 : cs[6], 1'b0, m};
        e.lwe = (k != 3'd0);
        e.swe = (k != 3'd0);
        e.sv  = (k != 3'd0) ? cs : 32'h0;
        return e;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic v, input logic [2:0] k, input logic [31:0] cs,
                         input logic hv, input logic [31:0] fa, input logic [31:0] na);
        exp_t e;
        string rq;
        trap_vld = v; trap_kind = k; cur_status = cs;
        hivec_en = hv; fault_addr = fa; next_addr = na;
        e = model(v, k, cs, hv, fa, na);
        @(negedge clk);
        if (!e.ld) begin
            rq = (v && k == 3'd7) ? "R10" : "R9";
            chk(rq, "pc_load", {31'd0, pc_load}, 32'd0);
            chk(rq, "status", new_status, e.st);
            chk(rq, "mode", {27'd0, tgt_mode}, {27'd0, e.md});
            chk(rq, "strobes", {29'd0, flush, link_we, save_we}, 32'd0);
            chk(rq, "data", pc_target | link_val | save_val, 32'd0);
        end else begin
            chk("R8", "pc_load/flush", {30'd0, pc_load, flush}, 32'd3);
            chk("R2", "tgt_mode", {27'd0, tgt_mode}, {27'd0, e.md});
            chk("R3", "pc_target", pc_target, e.tgt);
            chk("R4,R5", "new_status", new_status, e.st);
            chk("R6", "link_we", {31'd0, link_we}, {31'd0, e.lwe});
            chk("R6", "link_val", link_val, e.lnk);
            chk("R7", "save_we", {31'd0, save_we}, {31'd0, e.swe});
            chk("R7", "save_val", save_val, e.sv);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        rst_n = 1'b0; trap_vld = 1'b1; trap_kind = 3'd6; cur_status = 32'hFFFF_FFFF;
        hivec_en = 1'b1; fault_addr = 32'h1234; next_addr = 32'h5678;
        repeat (3) @(negedge clk);
        // R1: reset holds everything low even with a trap pending
        chk("R1", "pc_load", {31'd0, pc_load}, 32'd0);
        chk("R1", "strobes", {29'd0, flush, link_we, save_we}, 32'd0);
        chk("R1", "data", pc_target | link_val | save_val | new_status, 32'd0);
        rst_n = 1'b1;
        trap_vld = 1'b0;
        chk("R1", "first cycle", {31'd0, pc_load}, 32'd0);
        @(negedge clk);
        // Directed: every kind under both vector bases, with F clear and set
        for (int h = 0; h < 2; h++)
            for (int k = 0; k < 8; k++) begin
                apply(1'b1, 3'(k), 32'hA5A5_A510, h[0], 32'h0000_1000, 32'h0000_2004);
                apply(1'b1, 3'(k), 32'h0F0F_0F5F, h[0], 32'hFFFF_FFFC, 32'hFFFF_FFF8);
            end
        // R8: back-to-back traps give one pulse each, then an idle cycle drops it
        apply(1'b1, 3'd5, 32'h0000_00D3, 1'b0, 32'h40, 32'h44);
        apply(1'b1, 3'd6, 32'h0000_0092, 1'b0, 32'h40, 32'h48);
        apply(1'b0, 3'd6, 32'h0000_00D1, 1'b0, 32'h40, 32'h48);
        // Random mix
        for (int n = 0; n < 3000; n++)
            apply(($urandom % 10) < 7, 3'($urandom), $urandom, 1'($urandom),
                  $urandom, $urandom);
        finish_run();
    end
endmodule